// File: doc/BRIEF.md
# Branch and Program Counter Sequencer

This block owns the program counter and the stack pointer of a small 8-bit processor with 16-bit addresses. It decides where execution goes next for every kind of transfer:
- unconditional jumps and jumps on a flag condition;
- subroutine calls and returns, plain or on a flag condition;
- a load of the PC from the H/L register pair;
- software restarts to eight fixed slots;
- four internal interrupt levels, whose vectors sit four bytes above four of those slots.

One flag-condition evaluator serves jumps, calls and returns alike.

Calls, restarts and interrupts save the return address on a downward-growing stack through a byte-wide memory port. Returns fetch it back through the same port. Each stack transfer takes two memory cycles. The block drops `ready` while it runs one, and it ignores all new requests until `ready` rises again. The surrounding fetch logic presents one decoded branch request per cycle in which `ready` is high. The stack memory answers reads in the same cycle, without a register.

Top module: `bpc_sequencer`

## Requirements
- R1: During and right after synchronous reset, `pc` equals `PC_RESET`, `sp` equals `SP_RESET`, `ready` is 1 and neither `mem_we` nor `mem_re` is asserted.
- R2: `cond_sel` selects the condition as 0 = zero flag clear, 1 = zero set, 2 = carry clear, 3 = carry set, 4 = parity clear (odd), 5 = parity set (even), 6 = sign clear (positive), 7 = sign set (minus).
- R3: `op` code 1 (jump) loads `pc` with `operand` one cycle after acceptance. Code 2 (conditional jump) does the same when its condition holds, and otherwise sets `pc` to `pc`+3.
- R4: Code 3 (call), and code 4 (conditional call) with a true condition, each write the return address `pc`+3 to the stack: high byte at `sp`-1, low byte at `sp`-2. The block then sets `sp` to `sp`-2 and `pc` to `operand`; both are visible three cycles after acceptance. A conditional call with a false condition makes no memory write and leaves `sp` unchanged. It sets `pc` to `pc`+3 one cycle after acceptance.
- R5: Code 5 (return), and code 6 (conditional return) with a true condition, each read the low byte at `sp` and the high byte at `sp`+1. They load `pc` with that address and set `sp` to `sp`+2, three cycles after acceptance. A conditional return with a false condition does no memory access and sets `pc` to `pc`+1.
- R6: Code 7 loads `pc` with `{reg_h, reg_l}`, H in the upper byte, one cycle after acceptance.
- R7: Code 8 (restart) pushes `pc`+1 as a call does and sets `pc` to `rst_idx`×8, giving 0000h to 0038h.
- R8: An accepted interrupt pushes the current `pc` unchanged and vectors as follows: `irq_req[3]` to 0024h, `irq_req[2]` to 003Ch, `irq_req[1]` to 0034h, `irq_req[0]` to 002Ch.
- R9: When several `irq_req` bits are high, the highest-numbered one wins. `irq_ack` is one-hot on the winner in the accepting cycle and zero otherwise.
- R10: An interrupt offered in the same ready cycle as a branch request is taken, and the branch request is discarded.
- R11: Every stack transfer holds `ready` low for exactly two cycles. While `ready` is low, `op_valid` and `irq_req` have no effect and `irq_ack` stays zero.
- R12: `op` codes 0 and 9 to 15 leave `pc` and `sp` unchanged and keep `ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Branch request present |
| op | input | 4 | Decoded branch operation code |
| cond_sel | input | 3 | Flag condition selector |
| flag_sign | input | 1 | Sign flag |
| flag_zero | input | 1 | Zero flag |
| flag_parity | input | 1 | Parity flag (1 = even) |
| flag_carry | input | 1 | Carry flag |
| operand | input | 16 | Target address operand |
| reg_h | input | 8 | H register byte |
| reg_l | input | 8 | L register byte |
| rst_idx | input | 3 | Restart slot index |
| irq_req | input | 4 | Interrupt request strobes |
| irq_ack | output | 4 | One-hot acknowledge of the serviced interrupt |
| ready | output | 1 | Block can accept a request |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| mem_addr | output | 16 | Stack memory address |
| mem_we | output | 1 | Stack memory write strobe |
| mem_wdata | output | 8 | Stack memory write byte |
| mem_re | output | 1 | Stack memory read strobe |
| mem_rdata | input | 8 | Stack memory read byte (same cycle) |

## Verification
The bench builds the block with `PC_RESET` = FFF0h and `SP_RESET` = 0100h. The high start address means a few skipped conditional jumps carry the PC across FFFFh, so the 16-bit wrap of the fall-through step gets exercised early. The low stack base keeps every pushed byte inside a 256-byte memory model. Each saved return address can therefore be read back at its exact address, and deep call/return nesting stays within reach of the random sequence.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    localparam int AW    = 16;
    localparam int DW    = 8;
    localparam int N_IRQ = 4;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;

    typedef enum logic [3:0] {
        BR_NONE    = 4'd0,
        BR_JMP     = 4'd1,
        BR_JCOND   = 4'd2,
        BR_CALL    = 4'd3,
        BR_CCOND   = 4'd4,
        BR_RET     = 4'd5,
        BR_RCOND   = 4'd6,
        BR_LOADHL  = 4'd7,
        BR_RESTART = 4'd8
    } br_op_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic parity;
        logic carry;
    } flags_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_POP_LO,
        ST_POP_HI
    } seq_state_e;

    typedef struct packed {
        logic  push;
        logic  pop;
        addr_t next_pc;
        addr_t target;
        addr_t ret_addr;
    } plan_t;

    // Software restart slot n lands on n*8.
    function automatic addr_t restart_vec(input logic [2:0] n);
        return {{(AW-6){1'b0}}, n, 3'b000};
    endfunction

    // Interrupt level i sits four bytes above a restart slot:
    // level 3 above slot 4, levels 0..2 above slots 5..7.
    function automatic addr_t irq_vec(input int i);
        logic [2:0] slot;
        slot = (i == N_IRQ-1) ? 3'd4 : 3'(i + 5);
        return {{(AW-6){1'b0}}, slot, 3'b100};
    endfunction

endpackage

// File: rtl/bpc_cond_eval.sv
module bpc_cond_eval
    import bpc_pkg::*;
(
    input  logic [2:0] sel,
    input  flags_t     flags,
    output logic       taken
);
    // sel[2:1] picks the flag, sel[0] gives the value it must have (R2).
    logic [3:0] pick;

    assign pick  = {flags.sign, flags.parity, flags.carry, flags.zero};
    assign taken = (pick[sel[2:1]] == sel[0]);

endmodule

// File: rtl/bpc_irq_arbiter.sv
module bpc_irq_arbiter
    import bpc_pkg::*;
#(
    parameter int N = N_IRQ
)
(
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] ack,
    output logic         fire,
    output addr_t        vector
);
    logic [N-1:0] win;

    // Highest index wins (R9).
    for (genvar i = 0; i < N; i++) begin : g_pri
        if (i == N-1) begin : g_top
            assign win[i] = req[i];
        end else begin : g_low
            assign win[i] = req[i] & ~(|req[N-1:i+1]);
        end
    end

    assign ack  = en ? win : '0;
    assign fire = en & (|req);

    always_comb begin
        vector = '0;
        for (int i = 0; i < N; i++) begin
            if (win[i]) vector = irq_vec(i);
        end
    end

    a_r9_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack));

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r9_ack_has_req: assert property (@(posedge clk) disable iff (rst)
            ack[i] |-> (req[i] && fire));
    end

endmodule

// File: rtl/bpc_stack_port.sv
module bpc_stack_port
    import bpc_pkg::*;
#(
    parameter addr_t SP_RESET = '1
)
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state,
    input  addr_t      ret_addr,
    output addr_t      sp,
    output addr_t      mem_addr,
    output logic       mem_we,
    output logic       mem_re,
    output byte_t      mem_wdata
);
    localparam addr_t ONE = addr_t'(1);
    localparam addr_t TWO = addr_t'(2);

    // Stack grows downward; high byte sits at the higher address (R4, R5).
    always_comb begin
        mem_addr  = sp;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_HI: begin
                mem_addr  = sp - ONE;
                mem_we    = 1'b1;
                mem_wdata = ret_addr[AW-1:DW];
            end
            ST_PUSH_LO: begin
                mem_addr  = sp - TWO;
                mem_we    = 1'b1;
                mem_wdata = ret_addr[DW-1:0];
            end
            ST_POP_LO: begin
                mem_addr = sp;
                mem_re   = 1'b1;
            end
            ST_POP_HI: begin
                mem_addr = sp + ONE;
                mem_re   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= SP_RESET;
        end else if (state == ST_PUSH_LO) begin
            sp <= sp - TWO;
        end else if (state == ST_POP_HI) begin
            sp <= sp + TWO;
        end
    end

    a_r4_sp_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sp == $past(sp) || sp == $past(sp) - TWO || sp == $past(sp) + TWO));

    a_r5_port_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

endmodule

// File: rtl/bpc_sequencer.sv
module bpc_sequencer
    import bpc_pkg::*;
#(
    parameter addr_t PC_RESET  = '0,
    parameter addr_t SP_RESET  = '1,
    parameter int    LONG_LEN  = 3,
    parameter int    SHORT_LEN = 1
)
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [3:0]  op,
    input  logic [2:0]  cond_sel,
    input  logic        flag_sign,
    input  logic        flag_zero,
    input  logic        flag_parity,
    input  logic        flag_carry,
    input  logic [15:0] operand,
    input  logic [7:0]  reg_h,
    input  logic [7:0]  reg_l,
    input  logic [2:0]  rst_idx,
    input  logic [3:0]  irq_req,
    output logic [3:0]  irq_ack,
    output logic        ready,
    output logic [15:0] pc,
    output logic [15:0] sp,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata
);
    localparam addr_t LONG_STEP  = addr_t'(LONG_LEN);
    localparam addr_t SHORT_STEP = addr_t'(SHORT_LEN);

    seq_state_e state;
    addr_t      ret_q;
    addr_t      tgt_q;
    byte_t      lo_q;
    logic       taken;
    logic       irq_fire;
    addr_t      irq_target;
    flags_t     flg;
    plan_t      plan;

    assign flg   = '{sign: flag_sign, zero: flag_zero, parity: flag_parity, carry: flag_carry};
    assign ready = (state == ST_IDLE);

    bpc_cond_eval u_cond (
        .sel   (cond_sel),
        .flags (flg),
        .taken (taken)
    );

    bpc_irq_arbiter #(.N(N_IRQ)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .en     (ready),
        .req    (irq_req),
        .ack    (irq_ack),
        .fire   (irq_fire),
        .vector (irq_target)
    );

    bpc_stack_port #(.SP_RESET(SP_RESET)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .ret_addr  (ret_q),
        .sp        (sp),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata)
    );

    // Decision for the request presented in a ready cycle.
    always_comb begin
        plan = '{push: 1'b0, pop: 1'b0, next_pc: pc, target: pc, ret_addr: pc};
        if (irq_fire) begin
            // R8, R10: interrupt saves the current pc and beats any op.
            plan.push     = 1'b1;
            plan.target   = irq_target;
            plan.ret_addr = pc;
        end else if (op_valid) begin
            unique case (br_op_e'(op))
                BR_JMP:    plan.next_pc = operand;
                BR_JCOND:  plan.next_pc = taken ? operand : pc + LONG_STEP;
                BR_CALL: begin
                    plan.push     = 1'b1;
                    plan.target   = operand;
                    plan.ret_addr = pc + LONG_STEP;
                end
                BR_CCOND: begin
                    plan.push     = taken;
                    plan.target   = operand;
                    plan.ret_addr = pc + LONG_STEP;
                    plan.next_pc  = pc + LONG_STEP;
                end
                BR_RET:    plan.pop = 1'b1;
                BR_RCOND: begin
                    plan.pop     = taken;
                    plan.next_pc = pc + SHORT_STEP;
                end
                BR_LOADHL: plan.next_pc = {reg_h, reg_l};
                BR_RESTART: begin
                    plan.push     = 1'b1;
                    plan.target   = restart_vec(rst_idx);
                    plan.ret_addr = pc + SHORT_STEP;
                end
                default: ;  // R12
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pc    <= PC_RESET;
            ret_q <= '0;
            tgt_q <= '0;
            lo_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (plan.push) begin
                        ret_q <= plan.ret_addr;
                        tgt_q <= plan.target;
                        state <= ST_PUSH_HI;
                    end else if (plan.pop) begin
                        state <= ST_POP_LO;
                    end else begin
                        pc <= plan.next_pc;
                    end
                end
                ST_PUSH_HI: state <= ST_PUSH_LO;
                ST_PUSH_LO: begin
                    pc    <= tgt_q;
                    state <= ST_IDLE;
                end
                ST_POP_LO: begin
                    lo_q  <= mem_rdata;
                    state <= ST_POP_HI;
                end
                ST_POP_HI: begin
                    pc    <= {mem_rdata, lo_q};
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r11_busy_span: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |=> (!ready ##1 ready));

    a_r4_pc_held_mid_transfer: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PUSH_HI || state == ST_POP_LO) |=> $stable(pc));

    a_r10_irq_starts_push: assert property (@(posedge clk) disable iff (rst)
        (|irq_ack) |=> (mem_we && !ready));

    a_r12_unknown_noop: assert property (@(posedge clk) disable iff (rst)
        (ready && op_valid && !(|irq_req) && (op == 4'd0 || op > 4'd8))
            |=> ($stable(pc) && $stable(sp) && ready));

endmodule

// File: tb/bpc_sequencer_test.sv
module bpc_sequencer_test;

    localparam logic [15:0] PC_RST = 16'hFFF0;
    localparam logic [15:0] SP_RST = 16'h0100;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op;
    logic [2:0]  cond_sel;
    logic        flag_sign, flag_zero, flag_parity, flag_carry;
    logic [15:0] operand;
    logic [7:0]  reg_h, reg_l;
    logic [2:0]  rst_idx;
    logic [3:0]  irq_req;
    logic [3:0]  irq_ack;
    logic        ready;
    logic [15:0] pc, sp, mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  smem [0:255];
    logic [15:0] m_pc, m_sp;
    logic [15:0] m_stk [$];
    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bpc_sequencer #(.PC_RESET(PC_RST), .SP_RESET(SP_RST)) uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .cond_sel(cond_sel),
        .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_parity(flag_parity),
        .flag_carry(flag_carry), .operand(operand), .reg_h(reg_h), .reg_l(reg_l),
        .rst_idx(rst_idx), .irq_req(irq_req), .irq_ack(irq_ack), .ready(ready),
        .pc(pc), .sp(sp), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = smem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_we) smem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit cond_true(input logic [2:0] s, input logic [3:0] fl);
        // fl = {sign, zero, parity, carry}
        case (s)
            3'd0: return !fl[2];
            3'd1: return fl[2];
            3'd2: return !fl[0];
            3'd3: return fl[0];
            3'd4: return !fl[1];
            3'd5: return fl[1];
            3'd6: return !fl[3];
            default: return fl[3];
        endcase
    endfunction

    // Caller is at a negedge with ready high.
    task automatic run_op(input string tag, input logic [3:0] o, input logic [2:0] s,
                          input logic [3:0] fl, input logic [15:0] opnd,
                          input logic [7:0] hh, input logic [7:0] ll,
                          input logic [2:0] ix, input logic [3:0] irq);
        logic        push = 1'b0;
        logic        pop  = 1'b0;
        logic [15:0] nx   = m_pc;
        logic [15:0] ret  = m_pc;
        logic [3:0]  eack = 4'd0;
        logic [15:0] a_hi;
        bit          ok;
        int          cyc;
        ok = cond_true(s, fl);
        if (irq != 0) begin
            push = 1'b1;
            ret  = m_pc;
            if (irq[3])      begin eack = 4'b1000; nx = 16'h0024; end
            else if (irq[2]) begin eack = 4'b0100; nx = 16'h003C; end
            else if (irq[1]) begin eack = 4'b0010; nx = 16'h0034; end
            else             begin eack = 4'b0001; nx = 16'h002C; end
        end else begin
            case (o)
                4'd1: nx = opnd;
                4'd2: nx = ok ? opnd : m_pc + 16'd3;
                4'd3: begin push = 1'b1; ret = m_pc + 16'd3; nx = opnd; end
                4'd4: if (ok) begin push = 1'b1; ret = m_pc + 16'd3; nx = opnd; end
                      else nx = m_pc + 16'd3;
                4'd5: pop = 1'b1;
                4'd6: if (ok) pop = 1'b1; else nx = m_pc + 16'd1;
                4'd7: nx = {hh, ll};
                4'd8: begin push = 1'b1; ret = m_pc + 16'd1; nx = {10'd0, ix, 3'd0}; end
                default: nx = m_pc;
            endcase
        end
        op_valid = 1'b1; op = o; cond_sel = s;
        {flag_sign, flag_zero, flag_parity, flag_carry} = fl;
        operand = opnd; reg_h = hh; reg_l = ll; rst_idx = ix; irq_req = irq;
        #1;
        chk({tag, " R9 irq_ack"}, 32'(irq_ack), 32'(eack));
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0; irq_req = 4'd0;
        cyc = 1;
        while (!ready && cyc < 8) begin
            op_valid = 1'b1; op = 4'd1; operand = 16'($urandom);
            irq_req = 4'($urandom);
            #1;
            chk({tag, " R11 busy irq_ack"}, 32'(irq_ack), 32'd0);
            @(negedge clk);
            op_valid = 1'b0; irq_req = 4'd0;
            cyc++;
        end
        if (push) begin
            m_sp = m_sp - 16'd2;
            m_stk.push_back(ret);
        end
        if (pop) begin
            nx   = m_stk.pop_back();
            m_sp = m_sp + 16'd2;
        end
        m_pc = nx;
        chk({tag, " R11 cycles"}, 32'(cyc), (push || pop) ? 32'd3 : 32'd1);
        chk({tag, " pc"}, 32'(pc), 32'(m_pc));
        chk({tag, " sp"}, 32'(sp), 32'(m_sp));
        if (push) begin
            a_hi = m_sp + 16'd1;
            chk({tag, " R4 low byte"}, 32'(smem[m_sp[7:0]]), 32'(ret[7:0]));
            chk({tag, " R4 high byte"}, 32'(smem[a_hi[7:0]]), 32'(ret[15:8]));
        end
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) smem[i] = 8'h00;
        rst = 1'b1; op_valid = 1'b0; op = 4'd0; cond_sel = 3'd0;
        {flag_sign, flag_zero, flag_parity, flag_carry} = 4'd0;
        operand = 16'd0; reg_h = 8'd0; reg_l = 8'd0; rst_idx = 3'd0; irq_req = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pc in reset", 32'(pc), 32'(PC_RST));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pc", 32'(pc), 32'(PC_RST));
        chk("R1 sp", 32'(sp), 32'(SP_RST));
        chk("R1 ready", 32'(ready), 32'd1);
        chk("R1 mem strobes", 32'({mem_we, mem_re}), 32'd0);
        m_pc = PC_RST; m_sp = SP_RST;

        // R3: skipped conditional jumps wrap the pc past FFFFh.
        for (int i = 0; i < 6; i++) run_op("R3 jcond false wrap", 4'd2, 3'd1, 4'b0000, 16'h7777, 8'd0, 8'd0, 3'd0, 4'd0);
        chk("R3 wrapped pc", 32'(pc), 32'h0002);
        run_op("R3 jmp", 4'd1, 3'd0, 4'd0, 16'h4000, 8'd0, 8'd0, 3'd0, 4'd0);

        // R2: every selector against both values of its flag.
        for (int s = 0; s < 8; s++) begin
            for (int v = 0; v < 2; v++) begin
                logic [3:0] fl;
                fl = 4'($urandom);
                case (s / 2)
                    0: fl[2] = 1'(v);
                    1: fl[0] = 1'(v);
                    2: fl[1] = 1'(v);
                    default: fl[3] = 1'(v);
                endcase
                run_op("R2 cond select", 4'd2, 3'(s), fl, 16'h1000 + 16'(s*16 + v), 8'd0, 8'd0, 3'd0, 4'd0);
            end
        end

        run_op("R4 call", 4'd3, 3'd0, 4'd0, 16'h5000, 8'd0, 8'd0, 3'd0, 4'd0);
        run_op("R4 ccall false", 4'd4, 3'd3, 4'b0000, 16'h6000, 8'd0, 8'd0, 3'd0, 4'd0);
        run_op("R4 ccall true", 4'd4, 3'd3, 4'b0001, 16'h6000, 8'd0, 8'd0, 3'd0, 4'd0);
        run_op("R5 ret", 4'd5, 3'd0, 4'd0, 16'h0000, 8'd0, 8'd0, 3'd0, 4'd0);
        run_op("R5 cret false", 4'd6, 3'd7, 4'b0000, 16'h0000, 8'd0, 8'd0, 3'd0, 4'd0);
        run_op("R5 cret true", 4'd6, 3'd7, 4'b1000, 16'h0000, 8'd0, 8'd0, 3'd0, 4'd0);
        run_op("R6 load hl", 4'd7, 3'd0, 4'd0, 16'h0000, 8'hBE, 8'hEF, 3'd0, 4'd0);
        run_op("R7 restart 7", 4'd8, 3'd0, 4'd0, 16'h0000, 8'd0, 8'd0, 3'd7, 4'd0);
        run_op("R7 restart 0", 4'd8, 3'd0, 4'd0, 16'h0000, 8'd0, 8'd0, 3'd0, 4'd0);
        run_op("R8 level 3", 4'd0, 3'd0, 4'd0, 16'h0000, 8'd0, 8'd0, 3'd0, 4'b1000);
        run_op("R8 level 0", 4'd0, 3'd0, 4'd0, 16'h0000, 8'd0, 8'd0, 3'd0, 4'b0001);
        run_op("R8 level 1", 4'd0, 3'd0, 4'd0, 16'h0000, 8'd0, 8'd0, 3'd0, 4'b0010);
        run_op("R8 level 2", 4'd0, 3'd0, 4'd0, 16'h0000, 8'd0, 8'd0, 3'd0, 4'b0100);
        run_op("R9 all pending", 4'd0, 3'd0, 4'd0, 16'h0000, 8'd0, 8'd0, 3'd0, 4'b1111);
        run_op("R9 two pending", 4'd0, 3'd0, 4'd0, 16'h0000, 8'd0, 8'd0, 3'd0, 4'b0011);
        run_op("R10 irq beats jmp", 4'd1, 3'd0, 4'd0, 16'h9999, 8'd0, 8'd0, 3'd0, 4'b0100);
        run_op("R12 unknown op", 4'hC, 3'd0, 4'd0, 16'hAAAA, 8'd1, 8'd2, 3'd5, 4'd0);
        run_op("R12 zero op", 4'h0, 3'd0, 4'd0, 16'hAAAA, 8'd1, 8'd2, 3'd5, 4'd0);
        while (m_stk.size() > 0) run_op("R5 unwind", 4'd5, 3'd0, 4'd0, 16'd0, 8'd0, 8'd0, 3'd0, 4'd0);

        // Random mix.
        for (int n = 0; n < 600; n++) begin
            logic [3:0] o;
            logic [3:0] irq;
            o   = 4'($urandom_range(0, 12));
            irq = (($urandom % 8) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
            if (m_stk.size() >= 60 && (irq != 0 || o == 4'd3 || o == 4'd4 || o == 4'd8)) begin
                irq = 4'd0; o = 4'd1;
            end
            if (m_stk.size() == 0 && (o == 4'd5 || o == 4'd6)) o = 4'd7;
            run_op("random", o, 3'($urandom), 4'($urandom), 16'($urandom),
                   8'($urandom), 8'($urandom), 3'($urandom), irq);
        end

        finish_run();
    end

endmodule